// File: doc/BRIEF.md
# Channel Sum and Maximum Finder

This block takes one group of per-channel charge samples, all channels side by side, on every clock. From each group it forms four results: the total charge of the group, the largest single-channel charge and the index of the channel that holds it, and a flag raised when any channel sits at full scale. The channels are also divided into fixed patches of neighbouring channels. For each patch the block forms a partial sum, and it reports the first patch whose partial sum lies above a programmable minimum.

All results for one input group leave together after a fixed pipeline latency, marked by a valid strobe. The block takes a new group on every clock, so a downstream trigger stage can read a complete summary of each group in one cycle. The widths, the channel count and the patch size come from a shared package.

Top module: `chsum_top`

## Requirements
- R1: `out_total` equals the sum of all N_CH input samples of the group (default 16 channels of 8 bits, 12-bit total).
- R2: `out_max` equals the largest sample of the group.
- R3: `out_max_idx` is the channel index of the largest sample. Channel c occupies bits [c*8 +: 8] of `in_samples`. On a tie the lowest index is reported.
- R4: `out_sat` is 1 exactly when at least one sample equals the full-scale code 255. A sample of 254 does not raise it.
- R5: `out_patch_sums` holds one 10-bit sum per patch. Patch p covers channels 4p to 4p+3 and sits at bits [p*10 +: 10].
- R6: `out_patch_hit` is 1 when some patch sum is strictly greater than `patch_thr`, and `out_patch_idx` is then the lowest such patch. A sum equal to the threshold does not count. When no patch qualifies, both outputs are 0.
- R7: All outputs for a group appear together 4 clocks after the edge that samples it. `out_valid` is `in_valid` delayed by those 4 clocks, so it is high for exactly one cycle per accepted group.
- R8: While `rst` is high, `out_valid` and every result output are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a group on `in_samples` |
| in_samples | input | 128 | Sixteen 8-bit channel charges, channel 0 in the low bits |
| patch_thr | input | 10 | Minimum patch sum, sampled with the group |
| out_valid | output | 1 | Results below belong to a valid group |
| out_total | output | 12 | Sum of all channels |
| out_max | output | 8 | Largest channel charge |
| out_max_idx | output | 4 | Channel index of the largest charge |
| out_sat | output | 1 | A channel is at full scale |
| out_patch_sums | output | 40 | Four 10-bit patch sums, patch 0 in the low bits |
| out_patch_hit | output | 1 | Some patch sum exceeds the threshold |
| out_patch_idx | output | 2 | Lowest patch above the threshold |

## Verification
The bench places the maximum on two channels at once. A comparator that lets the later input win on equality would report channel 9 instead of channel 3. It sets the threshold exactly equal to two patch sums, which catches a `>=` comparison that would report a hit. It also uses patterns where a higher patch qualifies along with a lower one, which exposes an encoder that favours the highest index. Further patterns are one channel at 255 beside an all-254 group, which separates a full-scale test from a loose range test, and an all-255 group, which would wrap a total register that is one bit too narrow. Every group is checked exactly four clocks after it is sampled, and the strobe is checked to fall on the next cycle. Either check reports a stage missing from, or added to, the side path that runs beside the comparator tree.

// File: rtl/chsum_pkg.sv
package chsum_pkg;
    parameter int CH_W     = 8;
    parameter int N_CH     = 16;
    parameter int PATCH_CH = 4;

    localparam int IDX_W   = $clog2(N_CH);
    localparam int N_PATCH = N_CH / PATCH_CH;
    localparam int PIDX_W  = $clog2(N_PATCH);
    localparam int PS_W    = CH_W + $clog2(PATCH_CH);
    localparam int TOT_W   = CH_W + IDX_W;
    localparam int LVLS    = IDX_W;
    localparam int LAT     = LVLS;            // pipeline depth, needs LVLS >= 2
    localparam int SIDE_D  = LAT - 2;         // extra stages after the patch path
    localparam logic [CH_W-1:0] FULL = {CH_W{1'b1}};

    typedef struct packed {
        logic [CH_W-1:0]  val;
        logic [IDX_W-1:0] idx;
    } cand_t;

    typedef struct packed {
        logic [TOT_W-1:0]                 total;
        logic                             sat;
        logic                             hit;
        logic [PIDX_W-1:0]                pidx;
        logic [N_PATCH-1:0][PS_W-1:0]     sums;
    } side_t;

    // left operand carries the lower index, so it wins on equality
    function automatic cand_t pick(cand_t lo, cand_t hi);
        return (hi.val > lo.val) ? hi : lo;
    endfunction
endpackage

// File: rtl/chsum_argmax.sv
module chsum_argmax
    import chsum_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_CH*CH_W-1:0]   samples,
    output cand_t                  best
);
    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int NN = N_CH >> (l + 1);
        cand_t lhs  [NN];
        cand_t rhs  [NN];
        cand_t node [NN];

        for (genvar k = 0; k < NN; k++) begin : g_node
            if (l == 0) begin : g_leaf
                assign lhs[k] = '{val: samples[(2*k)*CH_W +: CH_W],   idx: IDX_W'(2*k)};
                assign rhs[k] = '{val: samples[(2*k+1)*CH_W +: CH_W], idx: IDX_W'(2*k+1)};
            end else begin : g_inner
                assign lhs[k] = g_lvl[l-1].node[2*k];
                assign rhs[k] = g_lvl[l-1].node[2*k+1];
            end
        end

        always_ff @(posedge clk) begin
            for (int k = 0; k < NN; k++) begin
                if (rst) node[k] <= '0;
                else     node[k] <= pick(lhs[k], rhs[k]);
            end
        end
    end

    assign best = g_lvl[LVLS-1].node[0];
endmodule

// File: rtl/chsum_patch.sv
module chsum_patch
    import chsum_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_CH*CH_W-1:0]   samples,
    input  logic [PS_W-1:0]        thr,
    output side_t                  side
);
    logic [N_PATCH-1:0][PS_W-1:0] sums_d, sums_q;
    logic                         sat_d,  sat_q;
    logic [PS_W-1:0]              thr_q;
    side_t                        side_d, side_q;

    // stage 1: patch sums and full-scale detect
    always_comb begin
        sat_d = 1'b0;
        for (int p = 0; p < N_PATCH; p++) begin
            logic [PS_W-1:0] acc;
            acc = '0;
            for (int c = 0; c < PATCH_CH; c++) begin
                acc = acc + PS_W'(samples[(p*PATCH_CH+c)*CH_W +: CH_W]);
                if (samples[(p*PATCH_CH+c)*CH_W +: CH_W] == FULL) sat_d = 1'b1;
            end
            sums_d[p] = acc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sums_q <= '0;
            sat_q  <= 1'b0;
            thr_q  <= '0;
        end else begin
            sums_q <= sums_d;
            sat_q  <= sat_d;
            thr_q  <= thr;
        end
    end

    // stage 2: total and lowest patch above threshold
    always_comb begin
        side_d       = '0;
        side_d.sums  = sums_q;
        side_d.sat   = sat_q;
        for (int p = 0; p < N_PATCH; p++)
            side_d.total = side_d.total + TOT_W'(sums_q[p]);
        for (int p = N_PATCH - 1; p >= 0; p--) begin
            if (sums_q[p] > thr_q) begin
                side_d.hit  = 1'b1;
                side_d.pidx = PIDX_W'(p);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) side_q <= '0;
        else     side_q <= side_d;
    end

    assign side = side_q;
endmodule

// File: rtl/chsum_delay.sv
module chsum_delay #(
    parameter int W = 8,
    parameter int D = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (D == 0) begin : g_wire
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] stg [D];
        always_ff @(posedge clk) begin
            for (int i = 0; i < D; i++) begin
                if (rst)        stg[i] <= '0;
                else if (i == 0) stg[i] <= d;
                else            stg[i] <= stg[i-1];
            end
        end
        assign q = stg[D-1];
    end
endmodule

// File: rtl/chsum_top.sv
module chsum_top
    import chsum_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [N_CH*CH_W-1:0]        in_samples,
    input  logic [PS_W-1:0]             patch_thr,
    output logic                        out_valid,
    output logic [TOT_W-1:0]            out_total,
    output logic [CH_W-1:0]             out_max,
    output logic [IDX_W-1:0]            out_max_idx,
    output logic                        out_sat,
    output logic [N_PATCH*PS_W-1:0]     out_patch_sums,
    output logic                        out_patch_hit,
    output logic [PIDX_W-1:0]           out_patch_idx
);
    cand_t          best;
    side_t          side_early, side_late;
    logic [LAT-1:0] vld_sh;

    chsum_argmax u_argmax (
        .clk     (clk),
        .rst     (rst),
        .samples (in_samples),
        .best    (best)
    );

    chsum_patch u_patch (
        .clk     (clk),
        .rst     (rst),
        .samples (in_samples),
        .thr     (patch_thr),
        .side    (side_early)
    );

    chsum_delay #(.W($bits(side_t)), .D(SIDE_D)) u_align (
        .clk (clk),
        .rst (rst),
        .d   (side_early),
        .q   (side_late)
    );

    always_ff @(posedge clk) begin
        if (rst) vld_sh <= '0;
        else     vld_sh <= {vld_sh[LAT-2:0], in_valid};
    end

    assign out_valid      = vld_sh[LAT-1];
    assign out_max        = best.val;
    assign out_max_idx    = best.idx;
    assign out_total      = side_late.total;
    assign out_sat        = side_late.sat;
    assign out_patch_sums = side_late.sums;
    assign out_patch_hit  = side_late.hit;
    assign out_patch_idx  = side_late.pidx;
endmodule

// File: rtl/chsum_chk.sv
module chsum_chk
    import chsum_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [N_CH*CH_W-1:0]        in_samples,
    input  logic [PS_W-1:0]             patch_thr,
    input  logic                        out_valid,
    input  logic [TOT_W-1:0]            out_total,
    input  logic [CH_W-1:0]             out_max,
    input  logic [IDX_W-1:0]            out_max_idx,
    input  logic                        out_sat,
    input  logic [N_PATCH*PS_W-1:0]     out_patch_sums,
    input  logic                        out_patch_hit,
    input  logic [PIDX_W-1:0]           out_patch_idx
);
    logic [LAT-1:0]  vd;
    logic [PS_W-1:0] thr_d [LAT];

    always_ff @(posedge clk) begin
        if (rst) vd <= '0;
        else     vd <= {vd[LAT-2:0], in_valid};
        for (int i = 0; i < LAT; i++) begin
            if (rst)         thr_d[i] <= '0;
            else if (i == 0) thr_d[i] <= patch_thr;
            else             thr_d[i] <= thr_d[i-1];
        end
    end

    // R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == vd[LAT-1]);

    // R4
    full_sets_sat_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_max == FULL |-> out_sat);

    // R4
    sat_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sat |-> out_max == FULL);

    // R1
    total_covers_max_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_total >= TOT_W'(out_max));

    // R6
    hit_above_thr_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_patch_hit |->
            out_patch_sums[out_patch_idx*PS_W +: PS_W] > thr_d[LAT-1]);

    // R6
    nohit_zero_idx_chk: assert property (@(posedge clk) disable iff (rst)
        !out_patch_hit |-> out_patch_idx == '0);

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && out_total == '0 && !out_sat);

    // unused in properties but part of the bound interface
    logic unused_ok;
    assign unused_ok = ^{in_samples, out_max_idx};
endmodule

bind chsum_top chsum_chk u_chk (.*);

// File: tb/tb_chsum_top.sv
module tb_chsum_top;
    import chsum_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic                        in_valid = 1'b0;
    logic [N_CH*CH_W-1:0]        in_samples = '0;
    logic [PS_W-1:0]             patch_thr = '0;
    logic                        out_valid;
    logic [TOT_W-1:0]            out_total;
    logic [CH_W-1:0]             out_max;
    logic [IDX_W-1:0]            out_max_idx;
    logic                        out_sat;
    logic [N_PATCH*PS_W-1:0]     out_patch_sums;
    logic                        out_patch_hit;
    logic [PIDX_W-1:0]           out_patch_idx;

    int n_chk  = 0;
    int n_fail = 0;
    int smp [N_CH];
    int thr;

    always #2.5 clk = ~clk;

    chsum_top dut (.*);

    task automatic chk(string req, string what, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // drive the group in smp/thr, wait the pipeline depth, compare everything
    task automatic run_group(string name);
        int tot = 0, mx = -1, mi = 0, sat = 0, hit = 0, pi = 0;
        int ps [N_PATCH];
        for (int c = 0; c < N_CH; c++) begin
            tot += smp[c];
            if (smp[c] > mx) begin mx = smp[c]; mi = c; end   // R3 lowest on tie
            if (smp[c] == 255) sat = 1;
        end
        for (int p = 0; p < N_PATCH; p++) begin
            ps[p] = 0;
            for (int c = 0; c < PATCH_CH; c++) ps[p] += smp[p*PATCH_CH + c];
        end
        for (int p = N_PATCH - 1; p >= 0; p--)
            if (ps[p] > thr) begin hit = 1; pi = p; end
        @(negedge clk);
        for (int c = 0; c < N_CH; c++) in_samples[c*CH_W +: CH_W] = CH_W'(smp[c]);
        patch_thr = PS_W'(thr);
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        in_samples = '0;
        patch_thr  = '0;
        repeat (LAT - 1) @(negedge clk);
        $display("group %s", name);
        chk("R7", "valid", out_valid, 1);
        chk("R1", "total", out_total, tot);
        chk("R2", "max", out_max, mx);
        chk("R3", "max idx", out_max_idx, mi);
        chk("R4", "sat", out_sat, sat);
        for (int p = 0; p < N_PATCH; p++)
            chk("R5", "patch sum", out_patch_sums[p*PS_W +: PS_W], ps[p]);
        chk("R6", "patch hit", out_patch_hit, hit);
        chk("R6", "patch idx", out_patch_idx, pi);
        @(negedge clk);
        chk("R7", "valid drop", out_valid, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R8", "valid", out_valid, 0);
        chk("R8", "total", out_total, 0);
        chk("R8", "max", out_max, 0);
        chk("R8", "sat", out_sat, 0);
        chk("R8", "patch hit", out_patch_hit, 0);
    endtask

    task automatic t_zeros();
        for (int c = 0; c < N_CH; c++) smp[c] = 0;
        thr = 0;                          // 0 > 0 is false: no hit
        run_group("zeros");
    endtask

    task automatic t_ramp();
        for (int c = 0; c < N_CH; c++) smp[c] = c * 10;
        thr = 300;                        // patches 2 and 3 exceed, 2 reported
        run_group("ramp");
    endtask

    task automatic t_tie();
        for (int c = 0; c < N_CH; c++) smp[c] = 5;
        smp[3] = 200; smp[9] = 200;       // R3 tie -> channel 3
        thr = 215;                        // equals patch 0 and 2 sums: R6 strict
        run_group("tie");
    endtask

    task automatic t_near_full();
        for (int c = 0; c < N_CH; c++) smp[c] = 254;   // R4 not raised
        thr = 1000;
        run_group("near_full");
    endtask

    task automatic t_one_full();
        for (int c = 0; c < N_CH; c++) smp[c] = 1;
        smp[12] = 255;                    // R4 raised, patch 3 only
        thr = 10;
        run_group("one_full");
    endtask

    task automatic t_all_full();
        for (int c = 0; c < N_CH; c++) smp[c] = 255;
        thr = 0;
        run_group("all_full");
    endtask

    task automatic t_mixed();
        for (int v = 0; v < 6; v++) begin
            for (int c = 0; c < N_CH; c++) smp[c] = int'($urandom_range(0, 255));
            thr = int'($urandom_range(200, 900));
            run_group("mixed");
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_zeros();
        t_ramp();
        t_tie();
        t_near_full();
        t_one_full();
        t_all_full();
        t_mixed();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule